// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is a memory-mapped register file for a general-purpose I/O port. The pins are split into groups of 32, and each group has its own small set of word registers at a fixed place in the address space. Software uses these registers to choose whether each pin drives or listens, to hold the level a driving pin puts out, and to read back the real pad level. A driving pin can also be read back.

The output latch can be changed in three ways. A plain write replaces every bit. Two alias addresses change only the bits marked by ones in the written mask: one alias raises those bits and the other lowers them. This lets two agents update different pins without a read-modify-write sequence. Pad levels pass through a two-stage synchroniser before they can be read, so a read soon after a change can still return the old level.

The register bus is a zero-wait port. A write is taken on the clock edge where the write enable is high. Read data is a combinational function of the address. Pin count and address width are parameters. Up to five groups fit the fixed address layout.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every direction bit reads 1, every output latch bit reads 0, and `pin_oe` is all zeros.
- R2: `pin_oe[n]` is the inverse of the direction bit of pin n. A direction bit of 1 means input and 0 means driven output. A write to the direction word takes effect on the next clock.
- R3: A write to the output word (group offset 0x4) replaces the whole latch of that group. `pin_out` follows the latch one clock after the write.
- R4: A write to the set alias (group offset 0x8) forces to 1 the latch bits that are 1 in the write data. All other bits keep their value.
- R5: A write to the clear alias (group offset 0xC) forces to 0 the latch bits that are 1 in the write data. All other bits keep their value.
- R6: A read of the set alias or the clear alias returns the current output latch of that group.
- R7: The input word (group offset 0x10) returns the pad level, including for driven pins. A pad change made before clock edge k reads old after edge k and new after edge k+1. Writes to this word are ignored.
- R8: Group g has its register set at address 0x10 + 0x28*g. The direction word is at offset 0x0 of that set. Pin n is bit n%32 of group n/32.
- R9: Reads of an address that is not one of the five aligned words of an existing group return zero. This covers 0x00–0x0F, the gaps between groups, misaligned addresses and addresses past the last group. Writes to these addresses change no pin and no register.
- R10: In a partly filled last group, bits at or above the pin count read as zero and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | NUM_PINS | Pad levels seen at the pins |
| pin_out | output | NUM_PINS | Output latch value driven to the pads |
| pin_oe | output | NUM_PINS | Output enable per pin, 1 = drive |

## Verification
A wrong latch or direction bit appears on `pin_out` or `pin_oe` one clock after the write that caused it. A read of the same group shows it at once. A decoder fault sends a write to the wrong group or register, and that group's pins show it on the next clock. The same fault makes a gap address return nonzero data on the spot. A synchroniser with the wrong depth shows up as a read of the input word that is one cycle early or one cycle late against the two-edge rule.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  // register select inside one group; the order follows the word offsets
  typedef enum logic [2:0] {
    REG_DIR  = 3'd0,
    REG_OUT  = 3'd1,
    REG_SET  = 3'd2,
    REG_CLR  = 3'd3,
    REG_IN   = 3'd4,
    REG_NONE = 3'd7
  } gpb_reg_e;

  localparam int GRP_FIRST  = 'h10;  // first group base
  localparam int GRP_STRIDE = 'h28;  // distance between group bases
  localparam int GRP_SPAN   = 'h14;  // five words per group
  localparam int GRP_MAX    = 5;     // groups that fit the layout

  function automatic int grp_base(input int g);
    return GRP_FIRST + GRP_STRIDE * g;
  endfunction

endpackage

// File: rtl/gpb_addr_dec.sv
module gpb_addr_dec
  import gpb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_GROUP = 5
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_GROUP-1:0] grp_hit,
  output gpb_reg_e             reg_sel
);

  always_comb begin
    grp_hit = '0;
    reg_sel = REG_NONE;
    for (int g = 0; g < NUM_GROUP; g++) begin
      int off;
      off = int'(addr) - grp_base(g);
      if ((off >= 0) && (off < GRP_SPAN) && ((off % 4) == 0)) begin
        grp_hit[g] = 1'b1;
        reg_sel    = gpb_reg_e'(off[4:2]);
      end
    end
  end

endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/gpb_group.sv
module gpb_group
  import gpb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         we,
  input  gpb_reg_e     reg_sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_sync,
  output logic [W-1:0] rdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q
);

  logic [W-1:0] dir_d;
  logic [W-1:0] out_d;
  logic         dir_en;
  logic         out_en;

  // next-state and clock enables
  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    dir_en = 1'b0;
    out_en = 1'b0;
    if (hit && we) begin
      case (reg_sel)
        REG_DIR: begin
          dir_d  = wdata;
          dir_en = 1'b1;
        end
        REG_OUT: begin
          out_d  = wdata;
          out_en = 1'b1;
        end
        REG_SET: begin
          out_d  = out_q | wdata;
          out_en = 1'b1;
        end
        REG_CLR: begin
          out_d  = out_q & ~wdata;
          out_en = 1'b1;
        end
        default: begin
          out_en = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (out_en) out_q <= out_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (hit) begin
      case (reg_sel)
        REG_DIR:                   rdata = dir_q;
        REG_OUT, REG_SET, REG_CLR: rdata = out_q;
        REG_IN:                    rdata = pad_sync;
        default:                   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 144,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  localparam int NUM_GROUP = (NUM_PINS + 31) / 32;

  logic                 rst_meta;
  logic                 rst_q;
  logic [NUM_PINS-1:0]  pad_sync;
  logic [NUM_GROUP-1:0] grp_hit;
  gpb_reg_e             reg_sel;
  logic [31:0]          grp_rd [NUM_GROUP];

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  gpb_sync #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d     (pin_in),
    .q     (pad_sync)
  );

  gpb_addr_dec #(.ADDR_W(ADDR_W), .NUM_GROUP(NUM_GROUP)) u_dec (
    .addr    (bus_addr),
    .grp_hit (grp_hit),
    .reg_sel (reg_sel)
  );

  for (genvar g = 0; g < NUM_GROUP; g++) begin : g_grp
    localparam int BW = ((NUM_PINS - 32 * g) >= 32) ? 32 : (NUM_PINS - 32 * g);
    logic [BW-1:0] rd_w;
    logic [BW-1:0] out_w;
    logic [BW-1:0] dir_w;

    gpb_group #(.W(BW)) u_grp (
      .clk      (clk),
      .rst_n    (rst_q),
      .hit      (grp_hit[g]),
      .we       (bus_we),
      .reg_sel  (reg_sel),
      .wdata    (bus_wdata[BW-1:0]),
      .pad_sync (pad_sync[32*g +: BW]),
      .rdata    (rd_w),
      .out_q    (out_w),
      .dir_q    (dir_w)
    );

    assign pin_out[32*g +: BW] = out_w;
    assign pin_oe[32*g +: BW]  = ~dir_w;
    assign grp_rd[g]           = 32'(rd_w);
  end

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NUM_GROUP; g++) begin
      bus_rdata = bus_rdata | grp_rd[g];
    end
  end

endmodule

// File: rtl/gpb_chk.sv
module gpb_chk
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 144,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_q,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);

  localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(grp_base(0));
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(grp_base(0) + 8);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(grp_base(0) + 12);
  localparam logic [ADDR_W-1:0] A_IN0  = ADDR_W'(grp_base(0) + 16);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(GRP_FIRST);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1: first cycle out of reset, nothing is driven
  p_oe_idle_r1: assert property (@(posedge clk)
    $rose(rst_q) |-> (pin_oe == '0));

  // R2: direction write sets the output enable to its inverse
  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == A_DIR0) |=> (pin_oe[31:0] == ~$past(bus_wdata)));

  // R4: set alias raises only the masked bits
  p_set_only_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == A_SET0) |=>
      (pin_out[31:0] == ($past(pin_out[31:0]) | $past(bus_wdata))));

  // R5: clear alias lowers only the masked bits
  p_clr_only_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == A_CLR0) |=>
      (pin_out[31:0] == ($past(pin_out[31:0]) & ~$past(bus_wdata))));

  // R7: input word shows the pads two edges late
  p_sync_lag_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (age_q >= 2'd2 && bus_addr == A_IN0) |-> (bus_rdata == $past(pin_in[31:0], 2)));

  // R9: low unmapped range reads zero
  p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_addr < A_LOW) |-> (bus_rdata == '0));

  // R9: writes to the low unmapped range leave all pins alone
  p_low_nowr_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr < A_LOW) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_bank_regs gpb_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_bank_regs_tb_top.sv
module gpio_bank_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 144;
  localparam int NG = 5;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic [NP-1:0] ext_in = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] m_dir [NG];
  logic [31:0] m_out [NG];

  // pad model: a driven pin sees its own output
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_in);

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_regs #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [31:0] gmask(int g);
    int w = NP - 32 * g;
    if (w >= 32) return 32'hFFFF_FFFF;
    return (32'h1 << w) - 32'h1;
  endfunction

  function automatic logic [AW-1:0] raddr(int g, int r);
    return AW'(16 + 40 * g + 4 * r);
  endfunction

  function automatic logic [31:0] slice(logic [NP-1:0] v, int g);
    logic [31:0] s = '0;
    for (int i = 0; i < 32; i++) if (32 * g + i < NP) s[i] = v[32 * g + i];
    return s;
  endfunction

  function automatic logic [31:0] pad_exp(int g);
    return ((~m_dir[g] & m_out[g]) | (m_dir[g] & slice(ext_in, g))) & gmask(g);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end in the low clock phase
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mwr(int g, int r, logic [31:0] d);
    wr(raddr(g, r), d);
    case (r)
      0: m_dir[g] = d & gmask(g);
      1: m_out[g] = d & gmask(g);
      2: m_out[g] = (m_out[g] | d) & gmask(g);
      3: m_out[g] = m_out[g] & ~d;
      default: ;
    endcase
  endtask

  task automatic chk_pins(string tag, int g);
    chk({tag, " pin_out"}, slice(pin_out, g), m_out[g]);
    chk({tag, " pin_oe"}, slice(pin_oe, g), ~m_dir[g] & gmask(g));
  endtask

  initial begin
    logic [31:0] v;
    logic [NP-1:0] so, se;
    void'($urandom(32'h0BAD_5EED));
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    for (int g = 0; g < NG; g++) begin
      m_dir[g] = gmask(g);
      m_out[g] = '0;
    end

    // R1: reset state
    for (int g = 0; g < NG; g++) begin
      rd(raddr(g, 0), v); chk("R1 dir reset", v, gmask(g));
      rd(raddr(g, 1), v); chk("R1 out reset", v, 32'h0);
    end
    chk("R1 pin_oe low", (pin_oe == '0) ? 32'h1 : 32'h0, 32'h1);

    // R2 R3: drive group 0
    mwr(0, 0, 32'h0000_FFFF);
    mwr(0, 1, 32'h1234_5678);
    chk_pins("R2 R3 group0", 0);
    rd(raddr(0, 1), v); chk("R3 out readback", v, 32'h1234_5678);

    // R4 R5 R6
    mwr(0, 2, 32'hF000_000F);
    rd(raddr(0, 1), v); chk("R4 set", v, 32'hF234_567F);
    mwr(0, 3, 32'h0230_0060);
    rd(raddr(0, 1), v); chk("R5 clear", v, 32'hF004_561F);
    rd(raddr(0, 2), v); chk("R6 set alias read", v, m_out[0]);
    rd(raddr(0, 3), v); chk("R6 clr alias read", v, m_out[0]);

    // R8: pin 100 is group 3 bit 4
    mwr(3, 0, 32'h0);
    mwr(3, 1, 32'h0);
    mwr(3, 2, 32'h0000_0010);
    chk("R8 pin100 out", {31'h0, pin_out[100]}, 32'h1);
    chk("R8 pin100 oe", {31'h0, pin_oe[100]}, 32'h1);
    chk_pins("R8 group3", 3);
    rd(raddr(3, 0), v); chk("R8 dir at base", v, 32'h0);

    // R10: partial last group
    mwr(4, 1, 32'hFFFF_FFFF);
    rd(raddr(4, 1), v); chk("R10 upper bits zero", v, 32'h0000_FFFF);
    mwr(4, 0, 32'h0);
    chk("R10 oe of last pins", {16'h0, pin_oe[143:128]}, 32'h0000_FFFF);
    rd(raddr(4, 0), v); chk("R10 dir upper zero", v, 32'h0);

    // R7: input latency with an external pad change
    mwr(0, 0, 32'hFFFF_FFFF);
    ext_in[31:0] = 32'hA5A5_0F0F;
    idle(3);
    rd(raddr(0, 4), v); chk("R7 settled", v, 32'hA5A5_0F0F);
    ext_in[31:0] = 32'h3C3C_F0F0;
    rd(raddr(0, 4), v); chk("R7 before edge", v, 32'hA5A5_0F0F);
    idle(1);
    rd(raddr(0, 4), v); chk("R7 after first edge", v, 32'hA5A5_0F0F);
    idle(1);
    rd(raddr(0, 4), v); chk("R7 after second edge", v, 32'h3C3C_F0F0);

    // R7: driven pin read back, same lag from the write edge
    mwr(0, 0, 32'h0);
    mwr(0, 1, 32'h0);
    idle(3);
    mwr(0, 2, 32'h0000_0001);
    rd(raddr(0, 4), v); chk("R7 loop old", v, 32'h0);
    idle(1);
    rd(raddr(0, 4), v); chk("R7 loop still old", v, 32'h0);
    idle(1);
    rd(raddr(0, 4), v); chk("R7 loop new", v, 32'h1);

    // R9: unmapped addresses and input-word writes
    so = pin_out; se = pin_oe;
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h12, 32'hFFFF_FFFF);
    wr(8'hC4, 32'hFFFF_FFFF);
    wr(8'hFC, 32'h0);
    wr(raddr(0, 4), 32'hFFFF_FFFF);
    chk("R9 pin_out kept", (pin_out == so) ? 32'h1 : 32'h0, 32'h1);
    chk("R9 pin_oe kept", (pin_oe == se) ? 32'h1 : 32'h0, 32'h1);
    rd(8'h00, v); chk("R9 read 0x00", v, 32'h0);
    rd(8'h24, v); chk("R9 read gap", v, 32'h0);
    rd(8'h16, v); chk("R9 read misaligned", v, 32'h0);
    rd(8'hC4, v); chk("R9 read past end", v, 32'h0);

    // random mix against the model
    for (int n = 0; n < 400; n++) begin
      int g = int'($urandom % NG);
      int r = int'($urandom % 5);
      logic [31:0] d = $urandom;
      if ($urandom % 2 == 1) begin
        mwr(g, r, d);
        chk_pins("R2 R3 R4 R5 random", g);
      end else if (r == 4) begin
        ext_in = {$urandom, $urandom, $urandom, $urandom, $urandom};
        idle(2);
        rd(raddr(g, 4), v); chk("R7 random input", v, pad_exp(g));
      end else begin
        rd(raddr(g, r), v);
        chk("R3 R6 random read", v, (r == 0) ? m_dir[g] : m_out[g]);
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule